// File: doc/BRIEF.md
# Keyhole stream packet dispatcher

This block sits behind a small write-only memory window. Software streams a configuration image into it one 32-bit word at a time. Four word writes make up one 128-bit quad. When the last word lands, the block decodes the quad and passes it to one of a row of frame engines, to all of them at once, or to none of them.

A quad can carry one of three things:

- **Frame packet.** It names a row and a register address, and it carries three data words.
- **Counter header.** It arms a frame-data counter and latches a destination row.
- **Raw payload.** While the counter is nonzero, each quad is payload. It goes unchanged to the frame-data register of the latched row.

A decompress control bit suppresses all dispatch. Reads of the window are not supported: they return zero and are flagged.

Top module: `kh_stream_dispatch`

## Requirements
- R1: A write with `wrEn` stores `wrData` into the slot picked by `addr[3:2]`. A write to slot 3 completes the quad, and the outputs of that quad appear on the clock edge that accepts the slot-3 write. The same write clears all four slots, so any slot not rewritten before the next completion contributes zero.
- R2: Word 0 of a completed quad is the header:
  - packet type in bits [31:24];
  - target row in bits [20:16];
  - register address in bits [13:8].
  - The other header bits are ignored.
- R3: With the counter at zero, a quad of type 8'h02 pulses the row vector for its target row and puts its register address on `rowReg`. `rowData` carries word 1 in [31:0], word 2 in [63:32], word 3 in [95:64] and zero in [127:96].
- R4: With the counter at zero, a quad of type 8'h01 whose register address is 6'h04 loads the counter from word 1. It also latches the header row as the payload destination and forwards nothing.
- R5: While the counter is nonzero, every completed quad is payload, whatever its header says. It is forwarded to the latched row with `rowReg` = 6'h04 and `rowData` = {word3, word2, word1, word0}, and the counter then drops by one.
- R6: A counter load whose value is not a multiple of 25 pulses `cntErr` one cycle after the slot-3 write, and the value is still loaded.
- R7: Row code 5'h1F pulses all 15 bits of `rowValid` together, for frame packets and for payload alike.
- R8: A forward to a row code from 15 to 30 pulses no `rowValid` bit and pulses `rowErr` instead.
- R9: While `decompEn` is high, a completed quad forwards nothing, loads nothing and leaves the counter unchanged.
- R10: `rdData` is always zero, and a cycle with `rdEn` high pulses `rdErr` on the following cycle.
- R11: `rowValid` is nonzero for exactly one cycle per forwarded quad.
- R12: A quad of any other type, or of type 8'h01 with a register address other than 6'h04, forwards nothing and leaves the counter at zero.
- R13: A synchronous reset clears the counter, the slots, `rowValid`, `rowReg`, `rowData` and all error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Window write strobe |
| rdEn | input | 1 | Window read strobe |
| addr | input | ADDR_W (12) | Byte address in the window; bits [3:2] pick the slot |
| wrData | input | 32 | Write data |
| decompEn | input | 1 | Decompress control; suppresses dispatch when high |
| rdData | output | 32 | Read data, always zero |
| rowValid | output | NUM_ROWS (15) | Per-row packet strobe, one-hot or all ones |
| rowReg | output | 6 | Register address of the forwarded packet |
| rowData | output | 128 | Four data words of the forwarded packet |
| rdErr | output | 1 | Pulse after an unsupported read |
| cntErr | output | 1 | Pulse after a counter load that is not a multiple of 25 |
| rowErr | output | 1 | Pulse after a forward to a row code with no port |

## Verification
The bench builds the block with its default parameters:

- 15 rows, which leaves codes 15 to 30 out of range, so the row-error path and the broadcast code 5'h1F can both be reached.
- Type codes 8'h01 and 8'h02 and frame-data register 6'h04, so one header bit pattern can be decoded as a frame packet while the counter is zero and as payload while it is armed.
- A count multiple of 25, which is small enough that a counter loaded with 25 can be drained in full. That puts the run-out edge, where payload ends and header decoding resumes, within reach of the run.

// File: rtl/kh_pkg.sv
package kh_pkg;
  localparam int WORD_W = 32;
  localparam int QUAD_WORDS = 4;
  localparam int QUAD_W = WORD_W * QUAD_WORDS;

  typedef struct packed {
    logic quadDone;
    logic sendPayload;
    logic loadCount;
    logic sendFrame;
  } khCtl_t;
endpackage

// File: rtl/kh_quad_ctrl.sv
module kh_quad_ctrl
  import kh_pkg::*;
#(
  parameter logic [7:0] TYPE_LOCAL = 8'h01,
  parameter logic [7:0] TYPE_FRAME = 8'h02,
  parameter int REG_W = 6,
  parameter logic [REG_W-1:0] REG_FDATA = 6'h04
) (
  input  logic             wrEn,
  input  logic [1:0]       slotSel,
  input  logic             decompEn,
  input  logic             cntBusy,
  input  logic [7:0]       hdrType,
  input  logic [REG_W-1:0] hdrReg,
  output khCtl_t           ctl
);
  localparam logic [1:0] LAST_SLOT = 2'(QUAD_WORDS - 1);

  logic active;
  logic isLoadHdr;
  logic isFrameHdr;

  always_comb begin
    ctl.quadDone    = wrEn && (slotSel == LAST_SLOT);
    active          = ctl.quadDone && !decompEn;
    isLoadHdr       = (hdrType == TYPE_LOCAL) && (hdrReg == REG_FDATA);
    isFrameHdr      = (hdrType == TYPE_FRAME);
    ctl.sendPayload = active && cntBusy;
    ctl.loadCount   = active && !cntBusy && isLoadHdr;
    ctl.sendFrame   = active && !cntBusy && isFrameHdr;
  end
endmodule

// File: rtl/kh_quad_dpath.sv
module kh_quad_dpath
  import kh_pkg::*;
#(
  parameter int NUM_ROWS = 15,
  parameter int ROW_W = 5,
  parameter int REG_W = 6,
  parameter int CNT_W = 32,
  parameter int CNT_MULT = 25,
  parameter logic [ROW_W-1:0] BCAST_ROW = 5'h1F,
  parameter logic [REG_W-1:0] REG_FDATA = 6'h04
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [1:0]          slotSel,
  input  logic [WORD_W-1:0]   wrData,
  input  khCtl_t              ctl,
  output logic [7:0]          hdrType,
  output logic [REG_W-1:0]    hdrReg,
  output logic                cntBusy,
  output logic [NUM_ROWS-1:0] rowValid,
  output logic [REG_W-1:0]    rowReg,
  output logic [QUAD_W-1:0]   rowData,
  output logic                cntErr,
  output logic                rowErr
);
  localparam logic [1:0] LAST_SLOT = 2'(QUAD_WORDS - 1);

  logic [WORD_W-1:0]   quadBuf [QUAD_WORDS-1];
  logic [QUAD_W-1:0]   fullQuad;
  logic [CNT_W-1:0]    cntVal;
  logic [ROW_W-1:0]    latchRow;
  logic [ROW_W-1:0]    destRow;
  logic [NUM_ROWS-1:0] rowHit;
  logic                isBcast;
  logic                badRow;
  logic                doSend;
  logic [WORD_W-1:0]   wordOne;

  // Slots 0..2 are held; slot 3 comes straight from the bus
  assign fullQuad = {wrData, quadBuf[2], quadBuf[1], quadBuf[0]};
  assign wordOne  = fullQuad[2*WORD_W-1:WORD_W];
  assign hdrType  = fullQuad[31:24];
  assign hdrReg   = fullQuad[8+REG_W-1:8];
  assign cntBusy  = (cntVal != '0);
  assign doSend   = ctl.sendPayload || ctl.sendFrame;
  assign destRow  = ctl.sendPayload ? latchRow : fullQuad[16+ROW_W-1:16];
  assign isBcast  = (destRow == BCAST_ROW);
  assign badRow   = !isBcast && (destRow >= ROW_W'(NUM_ROWS));

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowHit
    assign rowHit[r] = isBcast || (destRow == ROW_W'(r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < QUAD_WORDS - 1; i++) quadBuf[i] <= '0;
    end else if (wrEn) begin
      if (slotSel == LAST_SLOT) begin
        for (int i = 0; i < QUAD_WORDS - 1; i++) quadBuf[i] <= '0;
      end else begin
        quadBuf[slotSel] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal   <= '0;
      latchRow <= '0;
      cntErr   <= 1'b0;
    end else begin
      cntErr <= 1'b0;
      if (ctl.loadCount) begin
        cntVal   <= CNT_W'(wordOne);
        latchRow <= fullQuad[16+ROW_W-1:16];
        cntErr   <= (CNT_W'(wordOne) % CNT_W'(CNT_MULT)) != '0;
      end else if (ctl.sendPayload) begin
        cntVal <= cntVal - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowValid <= '0;
      rowReg   <= '0;
      rowData  <= '0;
      rowErr   <= 1'b0;
    end else begin
      rowValid <= doSend ? rowHit : '0;
      rowErr   <= doSend && badRow;
      if (ctl.sendPayload) begin
        rowReg  <= REG_FDATA;
        rowData <= fullQuad;
      end else if (ctl.sendFrame) begin
        rowReg  <= hdrReg;
        rowData <= {{WORD_W{1'b0}}, fullQuad[QUAD_W-1:WORD_W]};
      end
    end
  end

  AST_VALID_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (rowValid == '0) || $onehot(rowValid) || (&rowValid)); // R7
  AST_ROW_ERR_NO_PORT: assert property (@(posedge clk) disable iff (rst)
    rowErr |-> (rowValid == '0)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.sendPayload |=> (cntVal == $past(cntVal) - 1'b1)); // R5
  AST_CNT_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cntErr |-> $past(ctl.loadCount)); // R6
endmodule

// File: rtl/kh_stream_dispatch.sv
module kh_stream_dispatch
  import kh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_ROWS = 15,
  parameter int CNT_MULT = 25,
  parameter logic [7:0] TYPE_LOCAL = 8'h01,
  parameter logic [7:0] TYPE_FRAME = 8'h02,
  parameter logic [5:0] REG_FDATA = 6'h04
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  input  logic                decompEn,
  output logic [31:0]         rdData,
  output logic [NUM_ROWS-1:0] rowValid,
  output logic [5:0]          rowReg,
  output logic [127:0]        rowData,
  output logic                rdErr,
  output logic                cntErr,
  output logic                rowErr
);
  localparam int ROW_W = 5;
  localparam int REG_W = 6;

  khCtl_t           ctl;
  logic [1:0]       slotSel;
  logic [7:0]       hdrType;
  logic [REG_W-1:0] hdrReg;
  logic             cntBusy;
  logic             unusedAddr;

  assign slotSel    = addr[3:2];
  assign unusedAddr = ^{addr[ADDR_W-1:4], addr[1:0]};
  assign rdData     = '0;

  always_ff @(posedge clk) begin
    if (rst) rdErr <= 1'b0;
    else     rdErr <= rdEn;
  end

  kh_quad_ctrl #(
    .TYPE_LOCAL(TYPE_LOCAL), .TYPE_FRAME(TYPE_FRAME),
    .REG_W(REG_W), .REG_FDATA(REG_FDATA)
  ) ctrl_i (
    .wrEn(wrEn), .slotSel(slotSel), .decompEn(decompEn),
    .cntBusy(cntBusy), .hdrType(hdrType), .hdrReg(hdrReg), .ctl(ctl)
  );

  kh_quad_dpath #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .REG_W(REG_W), .CNT_W(32),
    .CNT_MULT(CNT_MULT), .BCAST_ROW(5'h1F), .REG_FDATA(REG_FDATA)
  ) dpath_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .slotSel(slotSel), .wrData(wrData),
    .ctl(ctl), .hdrType(hdrType), .hdrReg(hdrReg), .cntBusy(cntBusy),
    .rowValid(rowValid), .rowReg(rowReg), .rowData(rowData),
    .cntErr(cntErr), .rowErr(rowErr)
  );

  AST_DECOMP_DROP: assert property (@(posedge clk) disable iff (rst)
    (wrEn && slotSel == 2'd3 && decompEn) |=> (rowValid == '0)); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdErr); // R10
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && slotSel == 2'd3) |=> (rowValid == '0)); // R11
  AST_NO_CNT_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && slotSel == 2'd3) |=> !cntErr); // R6
endmodule

// File: tb/kh_stream_dispatch_tb.sv
module kh_stream_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wrData = '0;
  logic         decompEn = 1'b0;
  logic [31:0]  rdData;
  logic [14:0]  rowValid;
  logic [5:0]   rowReg;
  logic [127:0] rowData;
  logic         rdErr, cntErr, rowErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kh_stream_dispatch dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .decompEn(decompEn), .rdData(rdData),
    .rowValid(rowValid), .rowReg(rowReg), .rowData(rowData),
    .rdErr(rdErr), .cntErr(cntErr), .rowErr(rowErr)
  );

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
    logic [31:0] w3;
    logic [14:0] expValid;
    logic [5:0]  expReg;
    logic        expRowErr;
  } vec_t;

  // Frame packets (type 8'h02) with the counter at zero
  localparam vec_t VECS [6] = '{
    '{32'h0200_1100, 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 15'h0001, 6'h11, 1'b0},
    '{32'h020E_3F00, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_0000, 15'h4000, 6'h3F, 1'b0},
    '{32'h021F_0400, 32'h0000_0019, 32'hDEAD_BEEF, 32'hCAFE_F00D, 15'h7FFF, 6'h04, 1'b0},
    '{32'h020F_0500, 32'h0101_0101, 32'h0202_0202, 32'h0303_0303, 15'h0000, 6'h05, 1'b1},
    '{32'h021E_0200, 32'h0404_0404, 32'h0505_0505, 32'h0606_0606, 15'h0000, 6'h02, 1'b1},
    '{32'h02E7_C0FF, 32'h7777_7777, 32'h8888_8888, 32'h9999_9999, 15'h0080, 6'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] slot, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    addr = {8'h00, slot, 2'b00};
    wrData = d;
  endtask

  task automatic endWr();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendQuad(input logic [31:0] w0, w1, w2, w3);
    wr(2'd0, w0); wr(2'd1, w1); wr(2'd2, w2); wr(2'd3, w3);
    endWr();
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    chk(tag, 128'(rowValid), 128'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    chk("R13 rowValid after reset", 128'(rowValid), 128'h0);
    chk("R13 rowData after reset", rowData, 128'h0);
    chk("R13 errors after reset", 128'({rdErr, cntErr, rowErr, rowReg}), 128'h0);

    // R3 R2 R7 R8: table of frame packets
    foreach (VECS[i]) begin
      sendQuad(VECS[i].w0, VECS[i].w1, VECS[i].w2, VECS[i].w3);
      chk($sformatf("R3 vec%0d rowValid", i), 128'(rowValid), 128'(VECS[i].expValid));
      chk($sformatf("R8 vec%0d rowErr", i), 128'(rowErr), 128'(VECS[i].expRowErr));
      if (VECS[i].expValid != '0) begin
        chk($sformatf("R2 vec%0d rowReg", i), 128'(rowReg), 128'(VECS[i].expReg));
        chk($sformatf("R3 vec%0d rowData", i), rowData,
            {32'h0, VECS[i].w3, VECS[i].w2, VECS[i].w1});
      end
      idleCheck($sformatf("R11 vec%0d pulse width", i));
      chk($sformatf("R8 vec%0d rowErr clears", i), 128'(rowErr), 128'h0);
    end

    // R1: buffer zeroed after completion; partial quad
    wr(2'd0, 32'h0206_2100); wr(2'd3, 32'h0000_DDDD); endWr();
    chk("R1 partial quad rowValid", 128'(rowValid), 128'h0040);
    chk("R1 partial quad zeros", rowData, {32'h0, 32'h0000_DDDD, 32'h0, 32'h0});
    // R1: out-of-order slot fill
    wr(2'd2, 32'hC2C2_C2C2); wr(2'd0, 32'h0209_3000); wr(2'd1, 32'hB1B1_B1B1);
    wr(2'd3, 32'hD3D3_D3D3); endWr();
    chk("R1 out-of-order rowValid", 128'(rowValid), 128'h0200);
    chk("R1 out-of-order rowData", rowData, {32'h0, 32'hD3D3_D3D3, 32'hC2C2_C2C2, 32'hB1B1_B1B1});
    chk("R2 out-of-order rowReg", 128'(rowReg), 128'h30);

    // R4 R6: load count 2 to row 3 (not a multiple of 25)
    sendQuad(32'h0103_0400, 32'd2, 32'h0, 32'h0);
    chk("R4 load forwards nothing", 128'(rowValid), 128'h0);
    chk("R6 cntErr on count 2", 128'(cntErr), 128'h1);
    @(negedge clk);
    chk("R6 cntErr one pulse", 128'(cntErr), 128'h0);
    // R5: payload takes priority over a frame-looking header
    sendQuad(32'h0205_1100, 32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003);
    chk("R5 payload row", 128'(rowValid), 128'h0008);
    chk("R5 payload reg", 128'(rowReg), 128'h04);
    chk("R5 payload data", rowData, {32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001, 32'h0205_1100});
    // R9: decompress drops quad, counter unchanged
    decompEn = 1'b1;
    sendQuad(32'h0200_1100, 32'h1, 32'h2, 32'h3);
    chk("R9 decompress drop", 128'(rowValid), 128'h0);
    chk("R9 decompress no rowErr", 128'(rowErr), 128'h0);
    decompEn = 1'b0;
    sendQuad(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
    chk("R9 second payload still counted", 128'(rowValid), 128'h0008);
    chk("R5 second payload data", rowData, {32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h9ABC_DEF0, 32'h1234_5678});
    // R5: count exhausted, header decoding resumes
    sendQuad(32'h0205_1100, 32'h1, 32'h2, 32'h3);
    chk("R5 decode resumes", 128'(rowValid), 128'h0020);
    chk("R5 decode resumes reg", 128'(rowReg), 128'h11);

    // R6 R7: load 25 broadcast; drain
    sendQuad(32'h011F_0400, 32'd25, 32'h0, 32'h0);
    chk("R6 no cntErr on 25", 128'(cntErr), 128'h0);
    for (int k = 0; k < 25; k++) begin
      sendQuad(32'(k), 32'h0, 32'h0, 32'h0);
      chk($sformatf("R7 broadcast payload %0d", k), 128'(rowValid), 128'h7FFF);
    end
    // R12: unknown type and local type with other register
    sendQuad(32'h0703_1100, 32'h1, 32'h2, 32'h3);
    chk("R12 unknown type ignored", 128'(rowValid), 128'h0);
    sendQuad(32'h0103_0500, 32'd5, 32'h0, 32'h0);
    chk("R12 other local reg ignored", 128'(rowValid), 128'h0);
    chk("R12 no cntErr", 128'(cntErr), 128'h0);
    sendQuad(32'h0202_2200, 32'h1, 32'h2, 32'h3);
    chk("R12 counter not loaded", 128'(rowValid), 128'h0004);

    // R10: reads
    @(negedge clk);
    rdEn = 1'b1;
    #1 chk("R10 rdData zero", 128'(rdData), 128'h0);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R10 rdErr pulse", 128'(rdErr), 128'h1);
    @(negedge clk);
    chk("R10 rdErr clears", 128'(rdErr), 128'h0);

    // R13: reset clears an armed counter
    sendQuad(32'h0101_0400, 32'd10, 32'h0, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R13 rowData cleared", rowData, 128'h0);
    sendQuad(32'h0209_0700, 32'h1, 32'h2, 32'h3);
    chk("R13 counter cleared by reset", 128'(rowValid), 128'h0200);
    chk("R13 frame reg after reset", 128'(rowReg), 128'h07);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule